// File: doc/BRIEF.md
# Branch Target and Link Unit

This unit works out where the program counter goes next when a branch instruction executes in a 32-bit processor datapath. For each instruction it receives, it sees the instruction body with the condition field already removed. It also sees the program counter, already advanced by the prefetch distance of the current instruction address plus 8, and one register-file read value. The unit handles three kinds of branch. A PC-relative branch adds a sign-extended word offset to the program counter. A PC-relative branch with link does the same and also produces a return address for the link register. A register-indirect branch-and-exchange takes its target from a register, and bit 0 of that register picks the instruction-set state.

One instruction is accepted on each cycle in which the valid strobe is high. All results are registered and appear on the clock edge that samples the strobe. A taken branch raises a one-cycle flush so the fetch logic can discard its pipeline. The fetch logic then refills in the instruction-set state that the same edge presents. The unit does not evaluate condition codes, does not hold the register file and does not fetch.

Top module: `brtgt_unit`

## Requirements
- R1: After the synchronous active-low reset, `flush` and `link_we` are 0, `narrow_mode` is 0 (32-bit instruction mode) and `next_pc` is 0.
- R2: A relative branch is an accepted instruction with `op_body[27:25]` = 3'b101. On the next clock edge `next_pc` becomes `pc_in` plus `op_body[23:0]` shifted left by 2 and treated as a signed 26-bit value, with the sum wrapping at 32 bits.
- R3: A relative branch with `op_body[23]` = 1 moves backwards. The offset is sign-extended from its top bit, and this holds for the most negative offset 24'h800000 and the most positive offset 24'h7FFFFF.
- R4: A relative branch with the link bit `op_body[24]` = 1 pulses `link_we` for one cycle, with `link_data` = (`pc_in` − 4) and bits 1:0 cleared. With `op_body[24]` = 0, `link_we` stays 0.
- R5: A branch-and-exchange is an accepted instruction with `op_body[27:4]` = 24'h12FFF1. On the next edge `next_pc` becomes `reg_rdata` with bit 0 cleared, and `narrow_mode` becomes `reg_rdata[0]` (1 = 16-bit instruction mode, 0 = 32-bit mode). `link_we` stays 0.
- R6: `src_idx` always equals `op_body[3:0]` with no clock delay. This is the register index for the register-file read that feeds `reg_rdata`.
- R7: Every accepted branch of either kind raises `flush` for exactly one cycle after its strobe. Back-to-back branches keep it high on consecutive cycles. `flush` is never high in a cycle that does not follow an accepted branch.
- R8: A cycle with `in_valid` = 0, or an accepted instruction of any other encoding, leaves `next_pc` and `narrow_mode` unchanged and leaves `flush` and `link_we` at 0.
- R9: A relative branch does not change `narrow_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction strobe |
| op_body | input | 28 | Instruction bits 27:0, condition field removed |
| pc_in | input | 32 | Program counter including the prefetch offset |
| reg_rdata | input | 32 | Register-file value for branch-and-exchange |
| src_idx | output | 4 | Register index for the register-file read |
| next_pc | output | 32 | Registered branch target |
| link_we | output | 1 | Link-register write strobe, one cycle |
| link_data | output | 32 | Return address for the link register |
| flush | output | 1 | Pipeline flush pulse |
| narrow_mode | output | 1 | Instruction-set state, 1 = 16-bit mode |

## Verification
`src_idx` is combinational, so the bench checks it one time step after it drives `op_body`, before any clock edge. All other results are due on the first rising edge after the strobe. The bench drives inputs at a falling edge and samples the outputs at the next falling edge, which is half a cycle after the edge that loaded them. Idle cycles and non-branch words come between branches, so every sample also checks that `flush` and `link_we` dropped after one cycle and that the held target and mode did not move.

// File: rtl/brtgt_pkg.sv
package brtgt_pkg;

    localparam int XLEN      = 32;
    localparam int BODY_W    = 28;
    localparam int OFFS_W    = 24;
    localparam int IDX_W     = 4;

    typedef enum logic [1:0] {
        BK_NONE = 2'd0,
        BK_REL  = 2'd1,
        BK_EXCH = 2'd2
    } br_kind_e;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] link;
        logic            link_we;
        logic            flush;
        logic            narrow;
    } br_state_t;

endpackage

// File: rtl/brtgt_decode.sv
module brtgt_decode
    import brtgt_pkg::*;
#(
    parameter int BODY_W = brtgt_pkg::BODY_W,
    parameter int OFFS_W = brtgt_pkg::OFFS_W,
    parameter int IDX_W  = brtgt_pkg::IDX_W
) (
    input  logic [BODY_W-1:0] body,
    output br_kind_e          kind,
    output logic              link_bit,
    output logic [OFFS_W-1:0] offset,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [2:0]  REL_TAG  = 3'b101;
    localparam logic [23:0] EXCH_TAG = 24'h12FFF1;

    always_comb begin
        offset   = body[OFFS_W-1:0];
        link_bit = body[OFFS_W];
        idx      = body[IDX_W-1:0];
        if (body[27:25] == REL_TAG)
            kind = BK_REL;
        else if (body[27:4] == EXCH_TAG)
            kind = BK_EXCH;
        else
            kind = BK_NONE;
    end
endmodule

// File: rtl/brtgt_reladdr.sv
module brtgt_reladdr #(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 24,
    parameter int SHIFT  = 2,
    parameter int LINK_BACK = 4
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [OFFS_W-1:0] offset,
    output logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] link
);
    localparam int EXT_W = ADDR_W - OFFS_W - SHIFT;

    logic [ADDR_W-1:0] disp;
    logic [ADDR_W-1:0] back;

    always_comb begin
        disp   = {{EXT_W{offset[OFFS_W-1]}}, offset, {SHIFT{1'b0}}};
        target = pc + disp;
        back   = pc - ADDR_W'(LINK_BACK);
        link   = {back[ADDR_W-1:SHIFT], {SHIFT{1'b0}}};
    end
endmodule

// File: rtl/brtgt_exch.sv
module brtgt_exch #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] src,
    output logic [ADDR_W-1:0] target,
    output logic              narrow
);
    always_comb begin
        target = {src[ADDR_W-1:1], 1'b0};
        narrow = src[0];
    end
endmodule

// File: rtl/brtgt_unit.sv
module brtgt_unit
    import brtgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BODY_W-1:0] op_body,
    input  logic [XLEN-1:0]   pc_in,
    input  logic [XLEN-1:0]   reg_rdata,
    output logic [IDX_W-1:0]  src_idx,
    output logic [XLEN-1:0]   next_pc,
    output logic              link_we,
    output logic [XLEN-1:0]   link_data,
    output logic              flush,
    output logic              narrow_mode
);
    br_kind_e          kind;
    logic              link_bit;
    logic [OFFS_W-1:0] offset;
    logic [XLEN-1:0]   rel_tgt, rel_link, exch_tgt;
    logic              exch_narrow;
    br_state_t         st_d, st_q;

    brtgt_decode #(.BODY_W(BODY_W), .OFFS_W(OFFS_W), .IDX_W(IDX_W)) i_dec (
        .body(op_body), .kind(kind), .link_bit(link_bit),
        .offset(offset), .idx(src_idx)
    );

    brtgt_reladdr #(.ADDR_W(XLEN), .OFFS_W(OFFS_W)) i_rel (
        .pc(pc_in), .offset(offset), .target(rel_tgt), .link(rel_link)
    );

    brtgt_exch #(.ADDR_W(XLEN)) i_exch (
        .src(reg_rdata), .target(exch_tgt), .narrow(exch_narrow)
    );

    always_comb begin
        st_d         = st_q;
        st_d.flush   = 1'b0;
        st_d.link_we = 1'b0;
        if (in_valid) begin
            case (kind)
                BK_REL: begin
                    st_d.pc    = rel_tgt;
                    st_d.flush = 1'b1;
                    if (link_bit) begin
                        st_d.link_we = 1'b1;
                        st_d.link    = rel_link;
                    end
                end
                BK_EXCH: begin
                    st_d.pc     = exch_tgt;
                    st_d.narrow = exch_narrow;
                    st_d.flush  = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign next_pc     = st_q.pc;
    assign link_we     = st_q.link_we;
    assign link_data   = st_q.link;
    assign flush       = st_q.flush;
    assign narrow_mode = st_q.narrow;
endmodule

// File: rtl/brtgt_chk.sv
module brtgt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [27:0] op_body,
    input logic [31:0] reg_rdata,
    input logic [31:0] next_pc,
    input logic        link_we,
    input logic [31:0] link_data,
    input logic        flush,
    input logic        narrow_mode
);
    // R7
    flush_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !flush);

    // R4
    link_implies_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> flush);

    // R4
    link_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (link_data[1:0] == 2'b00));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(next_pc) && $stable(narrow_mode) && !link_we));

    // R5
    exch_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_body[27:4] == 24'h12FFF1)
            |=> (narrow_mode == $past(reg_rdata[0]) && !next_pc[0]));

    // R9
    rel_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_body[27:25] == 3'b101) |=> $stable(narrow_mode));
endmodule

bind brtgt_unit brtgt_chk i_brtgt_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_body(op_body),
    .reg_rdata(reg_rdata), .next_pc(next_pc), .link_we(link_we),
    .link_data(link_data), .flush(flush), .narrow_mode(narrow_mode)
);

// File: tb/test_brtgt_unit.sv
module test_brtgt_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [27:0] op_body = '0;
    logic [31:0] pc_in = '0;
    logic [31:0] reg_rdata = '0;
    logic [3:0]  src_idx;
    logic [31:0] next_pc, link_data;
    logic        link_we, flush, narrow_mode;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] m_pc = '0;
    logic        m_mode = 1'b0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    brtgt_unit i_brtgt_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_body(op_body),
        .pc_in(pc_in), .reg_rdata(reg_rdata), .src_idx(src_idx),
        .next_pc(next_pc), .link_we(link_we), .link_data(link_data),
        .flush(flush), .narrow_mode(narrow_mode)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] rel_target(input logic [31:0] pc, input logic [23:0] off);
        logic signed [31:0] d;
        d = 32'(signed'(off)) * 4;
        return pc + d;
    endfunction

    function automatic logic [31:0] link_addr(input logic [31:0] pc);
        logic [31:0] r;
        r = pc - 32'd4;
        return r & 32'hFFFF_FFFC;
    endfunction

    // Drive one cycle at a falling edge, check at the next falling edge.
    task automatic step(input logic v, input logic [27:0] b, input logic [31:0] pc,
                        input logic [31:0] rv);
        logic is_rel, is_exch, e_flush, e_link;
        logic [31:0] e_ld;
        in_valid = v; op_body = b; pc_in = pc; reg_rdata = rv;
        #1;
        chk("R6 src_idx", 32'(src_idx), 32'(b[3:0]));
        is_rel  = v && (b[27:25] == 3'b101);
        is_exch = v && (b[27:4] == 24'h12FFF1);
        e_flush = is_rel || is_exch;
        e_link  = is_rel && b[24];
        e_ld    = link_addr(pc);
        if (is_rel) m_pc = rel_target(pc, b[23:0]);
        if (is_exch) begin
            m_pc   = rv & 32'hFFFF_FFFE;
            m_mode = rv[0];
        end
        @(negedge clk);
        chk(is_exch ? "R5 next_pc" : (is_rel ? "R2 next_pc" : "R8 next_pc"), next_pc, m_pc);
        chk(is_exch ? "R5 mode" : "R9 R8 mode", 32'(narrow_mode), 32'(m_mode));
        chk("R7 flush", 32'(flush), 32'(e_flush));
        chk("R4 link_we", 32'(link_we), 32'(e_link));
        if (e_link) chk("R4 link_data", link_data, e_ld);
    endtask

    function automatic logic [27:0] mk_other(input logic [27:0] r);
        logic [27:0] b;
        b = r;
        if (b[27:25] == 3'b101) b[27] = 1'b0;
        if (b[27:4] == 24'h12FFF1) b[20] = 1'b0;
        return b;
    endfunction

    initial begin
        repeat (2000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 flush", 32'(flush), 32'd0);
        chk("R1 link_we", 32'(link_we), 32'd0);
        chk("R1 mode", 32'(narrow_mode), 32'd0);
        chk("R1 next_pc", next_pc, 32'd0);
        rst_n = 1'b1;
        // directed corners
        step(1'b1, {3'b101, 1'b0, 24'h7FFFFF}, 32'h0000_1008, 32'h0);   // R3 max positive
        step(1'b1, {3'b101, 1'b0, 24'h800000}, 32'h0400_0008, 32'h0);   // R3 most negative
        step(1'b1, {3'b101, 1'b1, 24'hFFFFFE}, 32'h0000_2003, 32'h0);   // R4 unaligned pc
        step(1'b0, 28'h0, 32'h0, 32'h0);                                // R7 pulse ends
        step(1'b1, 28'h12FFF13, 32'h0, 32'h0000_4001);                  // R5 to 16-bit
        step(1'b1, {3'b101, 1'b1, 24'h000010}, 32'h0000_0100, 32'h0);   // R9 mode kept
        step(1'b1, 28'h12FFF1E, 32'h0, 32'h8000_0000);                  // R5 back to 32-bit
        step(1'b1, 28'h12FFF00, 32'h1234_5678, 32'hFFFF_FFFF);          // R8 near miss
        step(1'b0, {3'b101, 1'b1, 24'h1}, 32'h10, 32'h0);               // R8 invalid strobe
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] k;
            logic [27:0] b;
            k = $urandom % 4;
            b = 28'($urandom);
            case (k)
                0: b[27:25] = 3'b101;
                1: b[27:4] = 24'h12FFF1;
                default: b = mk_other(b);
            endcase
            step((k == 3) ? 1'($urandom) : 1'b1, b, $urandom, $urandom);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule